// File: doc/BRIEF.md
# Emulated Flip-Flop Bank

This block provides four kinds of single-bit storage (data, toggle, J-K and set-reset) using only plain D registers. Each register's next state comes from sum-of-products logic that takes in its own stored value. Every kind is WIDTH lanes wide. Each lane has two outputs, a true output and a complement output, and each of the two has its own register. A complement register works out its next state from its own feedback. It is never the inverse of the true register.

All registers share one clock, one synchronous reset, and two synchronous controls: preset and clear. Clear wins over preset on every register. As a result, asserting both on the same edge leaves every true output LOW and every complement output HIGH. A small control module turns reset, preset and clear into a pair of strobes. The datapath module holds the next-state equations for all lanes.

Top module: `emu_ff_bank`

## Requirements
- R1: On a clock edge with `rst` high, every true output becomes 0 and every complement output becomes 1 (all bits of each vector).
- R2: On an edge with `clear` high, whatever the value of `preset` and the data inputs, every true output becomes 0 and every complement output becomes 1.
- R3: On an edge with `preset` high and `clear` low, every true output becomes 1 and every complement output becomes 0.
- R4: With both controls low, the data pair loads `dIn` into `dTrue` and the inverse of `dIn` into `dComp`, bit by bit.
- R5: With both controls low, each toggle register (true and complement) inverts its own stored bit where `tIn` is 1 and holds it where `tIn` is 0.
- R6: With both controls low, a `jkTrue` bit holds for J=0,K=0, goes to 0 for J=0,K=1, goes to 1 for J=1,K=0, and inverts for J=1,K=1.
- R7: With both controls low, a `jkComp` bit holds for J=0,K=0, goes to 1 for J=0,K=1, goes to 0 for J=1,K=0, and inverts its own stored value for J=1,K=1.
- R8: With both controls low, an `srTrue` bit goes to 1 when S=1, otherwise goes to 0 when R=1, otherwise holds.
- R9: With both controls low, an `srComp` bit goes to 1 when R=1, otherwise goes to 0 when S=1, otherwise holds. S=1 with R=1 therefore drives both outputs of that lane to 1.
- R10: From the first reset onward, the data, toggle and J-K pairs always stay exact bitwise inverses of each other.
- R11: Lanes are independent: bit i of every output depends only on bit i of the data inputs and on the shared controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| preset | input | 1 | Synchronous preset, active high |
| clear | input | 1 | Synchronous clear, active high, overrides preset |
| dIn | input | WIDTH | Data input for the data pair |
| tIn | input | WIDTH | Toggle enable |
| jIn | input | WIDTH | J input |
| kIn | input | WIDTH | K input |
| sIn | input | WIDTH | Set input |
| rIn | input | WIDTH | Reset input of the set-reset pair |
| dTrue | output | WIDTH | Data pair, true output |
| dComp | output | WIDTH | Data pair, complement output |
| tTrue | output | WIDTH | Toggle pair, true output |
| tComp | output | WIDTH | Toggle pair, complement output |
| jkTrue | output | WIDTH | J-K pair, true output |
| jkComp | output | WIDTH | J-K pair, complement output |
| srTrue | output | WIDTH | Set-reset pair, true output |
| srComp | output | WIDTH | Set-reset pair, complement output |

## Verification
The hardest condition to reach is a set-reset lane that has been pushed into the both-high state and must then be shown to diverge and recover correctly. This has to happen while the toggle and J-K pairs, which have no control of their own, stay mutually inverse. The stimulus gets there with a long random sweep in which S and R are often both high, interleaved with sparse preset, clear and reset cycles. A bit-level reference model, written as per-case rules rather than as equations, tracks every register across these events. Directed cycles add preset together with clear, and a single-lane toggle that checks lane isolation.

// File: rtl/ffbank_pkg.sv
package ffbank_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic forceOff;   // drive true registers low, complement registers high
    logic setOn;      // preset request (yields to forceOff on true registers)
  } ffCtl_t;
endpackage

// File: rtl/ffbank_ctrl.sv
module ffbank_ctrl
  import ffbank_pkg::*;
(
  input  logic   rst,
  input  logic   preset,
  input  logic   clear,
  output ffCtl_t ctl
);
  // Reset acts exactly like a clear on every register
  always_comb begin
    ctl.forceOff = rst | clear;
    ctl.setOn    = preset;
  end
endmodule

// File: rtl/ffbank_dp.sv
module ffbank_dp
  import ffbank_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  ffCtl_t           ctl,
  input  logic [WIDTH-1:0] dIn,
  input  logic [WIDTH-1:0] tIn,
  input  logic [WIDTH-1:0] jIn,
  input  logic [WIDTH-1:0] kIn,
  input  logic [WIDTH-1:0] sIn,
  input  logic [WIDTH-1:0] rIn,
  output logic [WIDTH-1:0] dTrue,
  output logic [WIDTH-1:0] dComp,
  output logic [WIDTH-1:0] tTrue,
  output logic [WIDTH-1:0] tComp,
  output logic [WIDTH-1:0] jkTrue,
  output logic [WIDTH-1:0] jkComp,
  output logic [WIDTH-1:0] srTrue,
  output logic [WIDTH-1:0] srComp
);
  localparam logic [WIDTH-1:0] ALL_ONE = {WIDTH{1'b1}};

  logic [WIDTH-1:0] dTNxt, dCNxt, tTNxt, tCNxt;
  logic [WIDTH-1:0] jkTNxt, jkCNxt, srTNxt, srCNxt;

  logic offT, preT, preC, offC;
  assign offT = ~ctl.forceOff;                 // ANDed into every true term
  assign preT = ctl.setOn & ~ctl.forceOff;     // preset term on true side
  assign preC = ~ctl.setOn;                    // ANDed into complement data terms
  assign offC = ctl.forceOff;                  // lone term on complement side

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_lane
      // data pair
      assign dTNxt[gi]  = (dIn[gi] & offT) | preT;
      assign dCNxt[gi]  = (~dIn[gi] & preC) | offC;
      // toggle pair, each from its own feedback
      assign tTNxt[gi]  = (tIn[gi] & ~tTrue[gi] & offT)
                        | (~tIn[gi] & tTrue[gi] & offT) | preT;
      assign tCNxt[gi]  = (tIn[gi] & ~tComp[gi] & preC)
                        | (~tIn[gi] & tComp[gi] & preC) | offC;
      // J-K pair, complement uses the dual rule
      assign jkTNxt[gi] = (jIn[gi] & ~jkTrue[gi] & offT)
                        | (~kIn[gi] & jkTrue[gi] & offT) | preT;
      assign jkCNxt[gi] = (kIn[gi] & ~jkComp[gi] & preC)
                        | (~jIn[gi] & jkComp[gi] & preC) | offC;
      // set-reset pair
      assign srTNxt[gi] = (sIn[gi] & offT)
                        | (~rIn[gi] & srTrue[gi] & offT) | preT;
      assign srCNxt[gi] = (rIn[gi] & preC)
                        | (~sIn[gi] & srComp[gi] & preC) | offC;
    end
  endgenerate

  always_ff @(posedge clk) begin
    dTrue  <= dTNxt;
    dComp  <= dCNxt;
    tTrue  <= tTNxt;
    tComp  <= tCNxt;
    jkTrue <= jkTNxt;
    jkComp <= jkCNxt;
    srTrue <= srTNxt;
    srComp <= srCNxt;
  end

  // R1/R2: clear or reset wins
  p_clear_wins_r2: assert property (@(posedge clk)
    ctl.forceOff |=> (dTrue == '0) && (tTrue == '0) && (jkTrue == '0) && (srTrue == '0)
                  && (dComp == ALL_ONE) && (tComp == ALL_ONE)
                  && (jkComp == ALL_ONE) && (srComp == ALL_ONE));

  // R3: preset alone
  p_preset_r3: assert property (@(posedge clk) disable iff (rst)
    (ctl.setOn && !ctl.forceOff) |=> (dTrue == ALL_ONE) && (srTrue == ALL_ONE)
                  && (tComp == '0) && (jkComp == '0));

  // R4: data load
  p_dload_r4: assert property (@(posedge clk) disable iff (rst)
    (!ctl.setOn && !ctl.forceOff) |=> (dTrue == $past(dIn)) && (dComp == ~$past(dIn)));

  // R5: toggle on own value
  p_toggle_r5: assert property (@(posedge clk) disable iff (rst)
    (!ctl.setOn && !ctl.forceOff) |=> (tComp == ($past(tComp) ^ $past(tIn))));

  // R9: S and R together drive both outputs high
  p_sr_both_r9: assert property (@(posedge clk) disable iff (rst)
    (!ctl.setOn && !ctl.forceOff) |=>
      ((srTrue & srComp & $past(sIn & rIn)) == $past(sIn & rIn)));

  // R10: non set-reset pairs stay inverse after reset
  p_inverse_r10: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> ((dTrue ^ dComp) == ALL_ONE) && ((tTrue ^ tComp) == ALL_ONE)
                 && ((jkTrue ^ jkComp) == ALL_ONE));
endmodule

// File: rtl/emu_ff_bank.sv
module emu_ff_bank
  import ffbank_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             preset,
  input  logic             clear,
  input  logic [WIDTH-1:0] dIn,
  input  logic [WIDTH-1:0] tIn,
  input  logic [WIDTH-1:0] jIn,
  input  logic [WIDTH-1:0] kIn,
  input  logic [WIDTH-1:0] sIn,
  input  logic [WIDTH-1:0] rIn,
  output logic [WIDTH-1:0] dTrue,
  output logic [WIDTH-1:0] dComp,
  output logic [WIDTH-1:0] tTrue,
  output logic [WIDTH-1:0] tComp,
  output logic [WIDTH-1:0] jkTrue,
  output logic [WIDTH-1:0] jkComp,
  output logic [WIDTH-1:0] srTrue,
  output logic [WIDTH-1:0] srComp
);
  ffCtl_t ctl;

  ffbank_ctrl u_ctrl (
    .rst    (rst),
    .preset (preset),
    .clear  (clear),
    .ctl    (ctl)
  );

  ffbank_dp #(.WIDTH(WIDTH)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ctl),
    .dIn    (dIn),
    .tIn    (tIn),
    .jIn    (jIn),
    .kIn    (kIn),
    .sIn    (sIn),
    .rIn    (rIn),
    .dTrue  (dTrue),
    .dComp  (dComp),
    .tTrue  (tTrue),
    .tComp  (tComp),
    .jkTrue (jkTrue),
    .jkComp (jkComp),
    .srTrue (srTrue),
    .srComp (srComp)
  );
endmodule

// File: tb/emu_ff_bank_tb.sv
module emu_ff_bank_tb;
  localparam int W = 4;
  localparam int SWEEP = 6000;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic rst, preset, clear;
  logic [W-1:0] dIn, tIn, jIn, kIn, sIn, rIn;
  logic [W-1:0] dTrue, dComp, tTrue, tComp, jkTrue, jkComp, srTrue, srComp;

  emu_ff_bank #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .preset(preset), .clear(clear),
    .dIn(dIn), .tIn(tIn), .jIn(jIn), .kIn(kIn), .sIn(sIn), .rIn(rIn),
    .dTrue(dTrue), .dComp(dComp), .tTrue(tTrue), .tComp(tComp),
    .jkTrue(jkTrue), .jkComp(jkComp), .srTrue(srTrue), .srComp(srComp)
  );

  int nRun = 0, nFail = 0;
  bit done = 0;

  // reference state
  logic [W-1:0] eD, eDc, eT, eTc, eJk, eJkc, eSr, eSrc;
  string tagNow;

  task automatic check(input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // advance the model for the inputs about to be clocked
  task automatic model_step();
    for (int i = 0; i < W; i++) begin
      if (rst || clear) begin
        eD[i]=0; eT[i]=0; eJk[i]=0; eSr[i]=0;
        eDc[i]=1; eTc[i]=1; eJkc[i]=1; eSrc[i]=1;
      end else if (preset) begin
        eD[i]=1; eT[i]=1; eJk[i]=1; eSr[i]=1;
        eDc[i]=0; eTc[i]=0; eJkc[i]=0; eSrc[i]=0;
      end else begin
        eD[i] = dIn[i]; eDc[i] = !dIn[i];
        if (tIn[i]) begin eT[i] = !eT[i]; eTc[i] = !eTc[i]; end
        case ({jIn[i], kIn[i]})
          2'b01: begin eJk[i] = 0; eJkc[i] = 1; end
          2'b10: begin eJk[i] = 1; eJkc[i] = 0; end
          2'b11: begin eJk[i] = !eJk[i]; eJkc[i] = !eJkc[i]; end
          default: ;
        endcase
        if (sIn[i]) eSr[i] = 1; else if (rIn[i]) eSr[i] = 0;
        if (rIn[i]) eSrc[i] = 1; else if (sIn[i]) eSrc[i] = 0;
      end
    end
    if (rst) tagNow = "R1"; else if (clear) tagNow = "R2";
    else if (preset) tagNow = "R3"; else tagNow = "";
  endtask

  task automatic check_all();
    if (tagNow != "") begin
      check(tagNow, "dTrue", dTrue, eD);   check(tagNow, "dComp", dComp, eDc);
      check(tagNow, "tTrue", tTrue, eT);   check(tagNow, "tComp", tComp, eTc);
      check(tagNow, "jkTrue", jkTrue, eJk); check(tagNow, "jkComp", jkComp, eJkc);
      check(tagNow, "srTrue", srTrue, eSr); check(tagNow, "srComp", srComp, eSrc);
    end else begin
      check("R4", "dTrue", dTrue, eD);     check("R4", "dComp", dComp, eDc);
      check("R5", "tTrue", tTrue, eT);     check("R5", "tComp", tComp, eTc);
      check("R6", "jkTrue", jkTrue, eJk);  check("R7", "jkComp", jkComp, eJkc);
      check("R8", "srTrue", srTrue, eSr);  check("R9", "srComp", srComp, eSrc);
    end
    // R10: inverse pairs
    check("R10", "d pair xor", dTrue ^ dComp, '1);
    check("R10", "t pair xor", tTrue ^ tComp, '1);
    check("R10", "jk pair xor", jkTrue ^ jkComp, '1);
  endtask

  // apply one cycle: inputs set at negedge, result checked next negedge
  task automatic cycle();
    model_step();
    @(negedge clk);
    check_all();
  endtask

  task automatic idle_inputs();
    rst = 0; preset = 0; clear = 0;
    dIn = '0; tIn = '0; jIn = '0; kIn = '0; sIn = '0; rIn = '0;
  endtask

  initial begin
    idle_inputs();
    rst = 1;
    eD='x; eDc='x; eT='x; eTc='x; eJk='x; eJkc='x; eSr='x; eSrc='x;
    @(negedge clk);
    cycle();                      // R1 reset state

    // R3 preset alone, with data inputs that would disagree
    idle_inputs(); preset = 1; dIn = '0; sIn = '0; rIn = '1;
    cycle();
    // R2 preset and clear together: clear wins
    idle_inputs(); preset = 1; clear = 1; dIn = '1; jIn = '1; sIn = '1;
    cycle();
    // R9 S and R both high drives both set-reset outputs high
    idle_inputs(); sIn = '1; rIn = '1;
    cycle();
    check("R9", "srTrue&srComp both high", srTrue & srComp, '1);
    // R11 single-lane toggle leaves other lanes alone
    idle_inputs(); tIn = 4'b0100;
    cycle();
    check("R11", "tTrue lane isolation", tTrue, 4'b0100);
    check("R11", "tComp lane isolation", tComp, 4'b1011);
    check("R11", "dTrue untouched by tIn", dTrue, 4'b0000);

    // random sweep with sparse controls
    for (int n = 0; n < SWEEP; n++) begin
      int c;
      c = $urandom_range(0, 63);
      rst = (c == 0);
      clear = (c >= 1 && c <= 5);
      preset = (c >= 4 && c <= 9);
      dIn = W'($urandom); tIn = W'($urandom); jIn = W'($urandom);
      kIn = W'($urandom); sIn = W'($urandom); rIn = W'($urandom);
      cycle();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule